// File: doc/BRIEF.md
# MDIO Management Command Engine

This block runs one clause-22 management transaction at a time toward external PHY devices. It has two registers behind a simple register port. Software places a 16-bit write value in the data register. It then writes the command register with a go bit, an opcode, a PHY address and a register address. The engine shifts the whole frame out on the management clock and data lines. It clears the go bit when the last bit has gone.

For a read, the engine releases the data line at the turnaround and samples the 16 bits that the PHY returns. It stores them in the upper half of the data register. Software polls the command register until the go bit is zero, then reads the result. The management clock is made from the system clock by a divider whose half period is a parameter. Outgoing bits change on the falling clock edge, and the PHY's bits are sampled on the rising edge.

Top module: `mdio_cmd_engine`

## Requirements
- R1: After reset both registers read zero, the management clock `mdc` is low, and the output enable `mdioOe` is low.
- R2: The command register, at address 0x680, keeps the go bit in bit 20, the opcode in bits 17:16, the PHY address in bits 12:8 and the register address in bits 4:0. All other bits read as zero, whatever was written to them. Opcode 01 is write, 10 is read, and 00 and 11 are reserved.
- R3: If the go bit is written with a reserved opcode, it clears on the next clock. `mdc` shows no rising edge and `mdioOe` never asserts.
- R4: A write frame is 64 bits, seen MSB first on the rising edges of `mdc`. It holds 32 ones, then 0 1, the opcode, the 5-bit PHY address, the 5-bit register address, turnaround 1 0, and data register bits 15:0. `mdioOe` is high for all 64 bits.
- R5: A read frame sends the same header up to the register address. `mdioOe` is low from the first turnaround bit (bit index 46) to the end of the frame. The 16 bits sampled on the last 16 rising edges are stored in data register bits 31:16, MSB first. Data register bits 15:0 are unchanged.
- R6: Each half period of `mdc` lasts HALF_DIV system clocks. The go bit reads zero exactly 128*HALF_DIV+1 clocks after the register write that set it, and the frame has exactly 64 rising edges.
- R7: The go bit reads one for the whole transaction and clears when it completes.
- R8: Writes to either register while the go bit is set are ignored. They change neither the frame on the wire nor the register contents.
- R9: While idle, the data register (address 0x681) reads back all 32 written bits. Any other address reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | ADDR_W | Register address for a read or write |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational from regAddr) |
| mdc | output | 1 | Management clock to the PHYs |
| mdioOut | output | 1 | Management data driven by the engine |
| mdioOe | output | 1 | Output enable for mdioOut |
| mdioIn | input | 1 | Management data from the line |

## Verification
A fault in the bit counter or the divider appears in the polled go-clear latency and in the count of `mdc` rising edges, within the transaction where it occurs. A shift-register or field-packing fault corrupts the 64-bit frame seen at the next rising edges. A fault in the direction control is seen as `mdioOe` being high from bit index 46 onward during a read. A capture fault appears in data bits 31:16 as soon as the go bit reads zero. A missing busy guard shows as register readback or frame data that has taken a mid-transaction write.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  typedef enum logic [1:0] {
    OP_RSV0  = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_RSV3  = 2'b11
  } mdioOp_e;

  localparam int FRAME_BITS = 64;
  localparam int CNT_W      = $clog2(FRAME_BITS);
  localparam int TA_BIT     = 46;
  localparam int DATA_BITS  = 16;

  typedef struct packed {
    logic load;
    logic shiftOut;
    logic sampleIn;
    logic finish;
  } mdioStrb_t;
endpackage

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      goPending,
  input  logic      opValid,
  input  logic      isRead,
  output mdioStrb_t strb,
  output logic      mdc,
  output logic      mdioOe
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] TA_IDX   = CNT_W'(TA_BIT);

  typedef enum logic {S_IDLE, S_RUN} state_e;
  state_e           state;
  logic             mdcQ;
  logic [CNT_W-1:0] bitCnt;
  logic             tick;
  logic             running;

  assign running = (state == S_RUN);

  generate
    if (HALF_DIV > 1) begin : g_div
      localparam int DW = $clog2(HALF_DIV);
      localparam logic [DW-1:0] DIV_LAST = DW'(HALF_DIV - 1);
      logic [DW-1:0] divCnt;
      always_ff @(posedge clk) begin
        if (!rstN || !running) divCnt <= '0;
        else if (divCnt == DIV_LAST) divCnt <= '0;
        else divCnt <= divCnt + 1'b1;
      end
      assign tick = running && (divCnt == DIV_LAST);
      // R6
      mdc_step_chk: assert property (@(posedge clk) disable iff (!rstN)
        !$stable(mdcQ) |-> ($past(divCnt) == DIV_LAST || $past(state) == S_IDLE));
    end else begin : g_nodiv
      assign tick = running;
    end
  endgenerate

  always_comb begin
    strb          = '0;
    strb.load     = !running && goPending && opValid;
    strb.sampleIn = tick && !mdcQ;
    strb.shiftOut = tick && mdcQ && (bitCnt != LAST_BIT);
    strb.finish   = (!running && goPending && !opValid) ||
                    (tick && mdcQ && (bitCnt == LAST_BIT));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      mdcQ   <= 1'b0;
      bitCnt <= '0;
    end else if (!running) begin
      mdcQ   <= 1'b0;
      bitCnt <= '0;
      if (strb.load) state <= S_RUN;
    end else if (tick) begin
      mdcQ <= ~mdcQ;
      if (mdcQ) begin
        if (bitCnt == LAST_BIT) state <= S_IDLE;
        else bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  assign mdc    = mdcQ;
  assign mdioOe = running && (!isRead || bitCnt < TA_IDX);

  // R7
  go_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    running |-> goPending);
  // R3
  rsv_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!running && goPending && !opValid) |=> (!running && !mdc));
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !running |-> (!mdc && !mdioOe));
endmodule

// File: rtl/mdio_dp.sv
module mdio_dp
  import mdio_pkg::*;
#(
  parameter int              ADDR_W    = 12,
  parameter logic [ADDR_W-1:0] CMD_ADDR  = 12'h680,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 12'h681
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  mdioStrb_t         strb,
  output logic              goPending,
  output logic              opValid,
  output logic              isRead,
  output logic              mdioOut,
  input  logic              mdioIn
);
  logic                  goBit;
  logic [1:0]            opReg;
  logic [4:0]            phyReg;
  logic [4:0]            regReg;
  logic [31:0]           dataReg;
  logic [FRAME_BITS-1:0] txShift;
  logic [DATA_BITS-1:0]  rxShift;
  logic                  wrCmd;
  logic                  wrData;

  assign wrCmd  = regWrEn && !goBit && (regAddr == CMD_ADDR);
  assign wrData = regWrEn && !goBit && (regAddr == DATA_ADDR);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      goBit   <= 1'b0;
      opReg   <= 2'b00;
      phyReg  <= '0;
      regReg  <= '0;
      dataReg <= '0;
      txShift <= '0;
      rxShift <= '0;
    end else begin
      if (wrCmd) begin
        goBit  <= regWrData[20];
        opReg  <= regWrData[17:16];
        phyReg <= regWrData[12:8];
        regReg <= regWrData[4:0];
      end
      if (wrData) dataReg <= regWrData;
      if (strb.load)
        txShift <= {32'hFFFF_FFFF, 2'b01, opReg, phyReg, regReg, 2'b10,
                    dataReg[DATA_BITS-1:0]};
      else if (strb.shiftOut)
        txShift <= {txShift[FRAME_BITS-2:0], 1'b1};
      if (strb.sampleIn) rxShift <= {rxShift[DATA_BITS-2:0], mdioIn};
      if (strb.finish) begin
        goBit <= 1'b0;
        if (isRead) dataReg[31:16] <= rxShift;
      end
    end
  end

  always_comb begin
    if (regAddr == CMD_ADDR)
      regRdData = {11'b0, goBit, 2'b0, opReg, 3'b0, phyReg, 3'b0, regReg};
    else if (regAddr == DATA_ADDR)
      regRdData = dataReg;
    else
      regRdData = '0;
  end

  assign goPending = goBit;
  assign opValid   = (opReg == OP_WRITE) || (opReg == OP_READ);
  assign isRead    = (opReg == OP_READ);
  assign mdioOut   = txShift[FRAME_BITS-1];

  // R8
  busy_data_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (goBit && regWrEn && !strb.finish) |=> $stable(dataReg));
  // R8
  busy_cmd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (goBit && regWrEn) |=> ($stable(opReg) && $stable(phyReg) && $stable(regReg)));
endmodule

// File: rtl/mdio_cmd_engine.sv
module mdio_cmd_engine
  import mdio_pkg::*;
#(
  parameter int                ADDR_W    = 12,
  parameter logic [ADDR_W-1:0] CMD_ADDR  = 12'h680,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 12'h681,
  parameter int                HALF_DIV  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output logic              mdc,
  output logic              mdioOut,
  output logic              mdioOe,
  input  logic              mdioIn
);
  mdioStrb_t strb;
  logic goPending, opValid, isRead;

  mdio_ctrl #(.HALF_DIV(HALF_DIV)) uCtrl (
    .clk(clk), .rstN(rstN), .goPending(goPending), .opValid(opValid),
    .isRead(isRead), .strb(strb), .mdc(mdc), .mdioOe(mdioOe)
  );

  mdio_dp #(.ADDR_W(ADDR_W), .CMD_ADDR(CMD_ADDR), .DATA_ADDR(DATA_ADDR)) uDp (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .strb(strb),
    .goPending(goPending), .opValid(opValid), .isRead(isRead),
    .mdioOut(mdioOut), .mdioIn(mdioIn)
  );
endmodule

// File: tb/mdio_cmd_engine_test.sv
module mdio_cmd_engine_test;
  localparam int HALF = 2;
  localparam logic [11:0] CMD = 12'h680;
  localparam logic [11:0] DAT = 12'h681;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        mdc, mdioOut, mdioOe;
  logic        mdioIn = 1'b1;

  int checks = 0, errors = 0;
  int riseCnt = 0, fallCnt = 0;
  logic [63:0] capBits, capOe;
  logic [15:0] phyVal = '0;
  bit oeSeen = 0;
  bit finished = 0;

  mdio_cmd_engine #(.HALF_DIV(HALF)) uut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .mdc(mdc),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  always #2 clk = ~clk;

  always @(posedge mdc) begin
    if (riseCnt < 64) begin
      capBits[63-riseCnt] = mdioOut;
      capOe[63-riseCnt]   = mdioOe;
    end
    riseCnt = riseCnt + 1;
  end

  always @(negedge mdc) begin
    fallCnt = fallCnt + 1;
    if (fallCnt >= 48 && fallCnt <= 63) mdioIn = phyVal[63-fallCnt];
    else mdioIn = 1'b1;
  end

  always @(posedge clk) if (mdioOe) oeSeen = 1;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  function automatic logic [31:0] cmdWord(input bit go, input logic [1:0] op,
                                          input logic [4:0] phy, input logic [4:0] rg);
    return {11'b0, go, 2'b0, op, 3'b0, phy, 3'b0, rg};
  endfunction

  function automatic logic [63:0] expFrame(input logic [1:0] op, input logic [4:0] phy,
                                           input logic [4:0] rg, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, op, phy, rg, 2'b10, d};
  endfunction

  task automatic runTxn(input logic [1:0] op, input logic [4:0] phy, input logic [4:0] rg,
                        input logic [31:0] wdata, input logic [15:0] rdVal, input bit busyWr);
    logic [31:0] rd;
    logic [63:0] mask, expOe;
    int n;
    bit valid;
    valid = (op == 2'b01) || (op == 2'b10);
    phyVal = rdVal;
    regWrite(DAT, wdata);
    riseCnt = 0; fallCnt = 0; oeSeen = 0;
    // reserved bits set in the written word must be dropped
    regWrite(CMD, cmdWord(1'b1, op, phy, rg) | 32'hFFE0_E0E0);
    n = 0;
    regAddr = CMD;
    #1 rd = regRdData;
    while (rd[20] && n < 5000) begin
      if (busyWr && (n == 5 || n == 6)) begin
        regAddr = (n == 5) ? DAT : CMD;
        regWrData = ~wdata;
        regWrEn = 1'b1;
      end
      @(posedge clk);
      @(negedge clk);
      regWrEn = 1'b0;
      regAddr = CMD;
      n++;
      #1 rd = regRdData;
    end
    if (!valid) begin
      // R3
      chk(n == 1, "R3 go-clear cycles", n, 1);
      chk(riseCnt == 0 && !oeSeen, "R3 bus quiet", {riseCnt, 31'b0, oeSeen}, 0);
    end else begin
      // R6
      chk(n == 128*HALF+1, "R6 go-clear latency", n, 128*HALF+1);
      chk(riseCnt == 64, "R6 rising edge count", riseCnt, 64);
      if (op == 2'b01) begin
        // R4
        chk(capBits == expFrame(op, phy, rg, wdata[15:0]), "R4 write frame",
            capBits, expFrame(op, phy, rg, wdata[15:0]));
        chk(capOe == '1, "R4 oe during write", capOe, '1);
        regRead(DAT, rd);
        // R8
        chk(rd == wdata, "R8 data register after write", rd, wdata);
      end else begin
        mask  = {{46{1'b1}}, 18'b0};
        expOe = mask;
        // R5
        chk((capBits & mask) == (expFrame(op, phy, rg, 16'h0) & mask), "R5 read header",
            capBits & mask, expFrame(op, phy, rg, 16'h0) & mask);
        chk(capOe == expOe, "R5 oe release", capOe, expOe);
        regRead(DAT, rd);
        chk(rd == {rdVal, wdata[15:0]}, "R5 read result", rd, {rdVal, wdata[15:0]});
      end
    end
    regRead(CMD, rd);
    // R7 R2
    chk(rd == cmdWord(1'b0, op, phy, rg), "R7 command after completion", rd,
        cmdWord(1'b0, op, phy, rg));
  endtask

  initial begin
    #200000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL R7 watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, r;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    // R1
    regRead(CMD, rd);
    chk(rd == 0, "R1 command reset", rd, 0);
    regRead(DAT, rd);
    chk(rd == 0, "R1 data reset", rd, 0);
    chk(!mdc && !mdioOe, "R1 lines idle", {mdc, mdioOe}, 0);
    // R2: all ones except go
    regWrite(CMD, 32'hFFEF_FFFF);
    regRead(CMD, rd);
    chk(rd == 32'h0003_1F1F, "R2 field mask", rd, 32'h0003_1F1F);
    // R9
    r = $urandom;
    regWrite(DAT, r);
    regRead(DAT, rd);
    chk(rd == r, "R9 data readback", rd, r);
    regRead(12'h123, rd);
    chk(rd == 0, "R9 unmapped read", rd, 0);
    // directed
    runTxn(2'b01, 5'd0, 5'd0, 32'h0, 16'h0, 0);
    runTxn(2'b10, 5'd31, 5'd31, 32'hABCD_1234, 16'hFFFF, 0);
    runTxn(2'b10, 5'd1, 5'd17, 32'h0000_5A5A, 16'h8001, 0);
    runTxn(2'b00, 5'd3, 5'd4, 32'h1111_2222, 16'h0, 0);
    runTxn(2'b11, 5'd9, 5'd2, 32'h3333_4444, 16'h0, 0);
    // R8 busy writes
    runTxn(2'b01, 5'd7, 5'd20, 32'hDEAD_00E2, 16'h0, 1);
    runTxn(2'b10, 5'd2, 5'd11, 32'h0000_0D01, 16'h6C3A, 1);
    // random
    for (int i = 0; i < 10; i++) begin
      logic [1:0] op;
      op = ($urandom % 2 == 0) ? 2'b01 : 2'b10;
      runTxn(op, 5'($urandom), 5'($urandom), $urandom, 16'($urandom), ($urandom % 3) == 0);
    end
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule